// File: doc/BRIEF.md
# Tracking-Converter Position Counter

This block holds the digital angle of a tracking angle converter as an N-bit up/down count. Each step pulse from the upstream tracking loop moves the count by one LSB. A direction input picks whether the step adds or subtracts. The count wraps modulo 2^N, and a ripple output pulses for one cycle whenever the count passes through zero in either direction. A busy flag marks each cycle in which a new count value appears. The registered direction output always changes at least one cycle before the count update that it qualifies.

Software or a supervisor can preset the count through a parallel load. The load is accepted only while the data outputs are released. The load strobe and the applied word must be held for a set number of cycles, which models a hold time. When the active-low complement input is inactive, the load writes the word into the count. When the complement input is active, the load instead clears every count bit that is 1 in the word and leaves the other bits as they were. The data outputs drive the count while the active-low output enable is low, and they float while it is high.

Top module: `angle_pos_counter`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), the count is 0 and dir_o, busy_o and ripple_o are all 0.
- R2: A step_i sampled high at clock edge k changes the count at edge k+1. The count goes up by 1 if dir_i was 1 at edge k, and down by 1 if dir_i was 0.
- R3: The count wraps modulo 2^WIDTH. Stepping up from all-ones gives 0, and stepping down from 0 gives all-ones. In both cases ripple_o is 1 for exactly the cycle in which the wrapped value first appears. ripple_o is 0 at every other time, including after loads.
- R4: busy_o is 1 for exactly one cycle for each count update, whether from a step or from a load, and in the same cycle as the new value. It is 0 in all other cycles.
- R5: dir_o takes the value of dir_i one edge after sampling, so dir_o shows a step's direction one cycle before that step's count change. Toggling dir_i without any step leaves the count unchanged.
- R6: A load with comp_n_i high (inactive) sets the count to data_i.
- R7: A load with comp_n_i low (active) sets the count to count AND NOT data_i. For example, count 0x015 with data 0x018 gives 0x005.
- R8: A load takes effect only on the HOLD_CYCLES-th consecutive clock edge at which load_n_i is low and oe_n_i is high, and it uses data_i as it is at that edge. A shorter strobe has no effect. A strobe held longer still loads only once.
- R9: While oe_n_i is low, load_n_i is ignored.
- R10: A step that would apply at the same edge as a load is discarded. The count takes the load result only.
- R11: While oe_n_i is low, data_o carries the current count combinationally, with no cycle delay. While oe_n_i is high, data_o is high impedance.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| step_i | input | 1 | One-LSB step pulse from the tracking loop |
| dir_i | input | 1 | Step direction, 1 = up, 0 = down |
| load_n_i | input | 1 | Active-low load strobe |
| comp_n_i | input | 1 | Active-low complement select for a load (high = plain load) |
| oe_n_i | input | 1 | Active-low output enable for data_o |
| data_i | input | WIDTH | Word applied during a load |
| data_o | output | WIDTH | Count, or high impedance while oe_n_i is high |
| dir_o | output | 1 | Registered direction |
| busy_o | output | 1 | High in each cycle a new count appears |
| ripple_o | output | 1 | One-cycle pulse when the count wraps |

## Verification
The bench sends runs of upward steps, and then a downward run that crosses zero. These separate correct increment and decrement arithmetic from a wrong sign, and they show whether ripple appears only on a real wrap. Bursts of direction toggles with no step separate a count driven by steps from one driven by direction changes. Two loads use the same starting count and the same word, one plain and one with complement, which separates overwrite from clear-under-mask. Strobes one cycle too short, strobes made while the outputs are enabled, and a step placed on the commit edge show the hold window, the enable gate and the load priority.

// File: rtl/pos_pkg.sv
// Shared types for the position counter.
// Assumes: nothing beyond IEEE 1800-2017.
package pos_pkg;
    typedef enum logic {
        LD_WRITE = 1'b0,   // count <= word
        LD_CLEAR = 1'b1    // count <= count & ~word
    } load_kind_e;
endpackage

// File: rtl/pos_dir_stage.sv
// Direction / step register stage.
// Registers the direction and step inputs for one cycle. As a result the
// direction output is valid one cycle before the count update it qualifies.
// Assumes: step_i and dir_i are synchronous to clk.
module pos_dir_stage (
    input  logic clk,
    input  logic rst_n,
    input  logic step_i,
    input  logic dir_i,
    output logic step_q,
    output logic dir_q
);
    // capture direction and step one edge ahead of the count update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step_q <= 1'b0;
            dir_q  <= 1'b0;
        end else begin
            step_q <= step_i;
            dir_q  <= dir_i;
        end
    end
endmodule

// File: rtl/pos_load_hold.sv
// Load hold-window controller.
// Counts consecutive edges with the load strobe active and outputs disabled.
// It issues one commit pulse on the HOLD_CYCLES-th such edge. It rearms only
// after the strobe is released or the outputs are enabled.
// Assumes: HOLD_CYCLES >= 1.
module pos_load_hold #(
    parameter int HOLD_CYCLES = 25
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_n_i,
    input  logic               oe_n_i,
    input  logic               comp_n_i,
    output logic               ld_go,
    output pos_pkg::load_kind_e ld_kind
);
    localparam int HW = $clog2(HOLD_CYCLES + 1);
    localparam logic [HW-1:0] LAST = HW'(HOLD_CYCLES - 1);
    localparam logic [HW-1:0] SAT  = HW'(HOLD_CYCLES);

    logic          req;
    logic [HW-1:0] hcnt;

    // a load request counts only while outputs are released
    assign req     = !load_n_i && oe_n_i;
    assign ld_go   = req && (hcnt == LAST);
    assign ld_kind = comp_n_i ? pos_pkg::LD_WRITE : pos_pkg::LD_CLEAR;

    // track how long the request has been held, saturating after commit
    always_ff @(posedge clk) begin
        if (!rst_n || !req)
            hcnt <= '0;
        else if (hcnt != SAT)
            hcnt <= hcnt + 1'b1;
    end

    AST_ONE_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        ld_go |=> !ld_go); // R8
endmodule

// File: rtl/pos_count_core.sv
// Position count register with step, wrap and load handling.
// A load at an edge overrides any step at that edge. Busy and ripple are
// registered so they line up with the cycle where the new count appears.
// Assumes: ld_data is stable at the commit edge.
module pos_count_core #(
    parameter int WIDTH = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                step_q,
    input  logic                dir_q,
    input  logic                ld_go,
    input  pos_pkg::load_kind_e ld_kind,
    input  logic [WIDTH-1:0]    ld_data,
    output logic [WIDTH-1:0]    count,
    output logic                busy,
    output logic                ripple
);
    localparam logic [WIDTH-1:0] ALL1 = {WIDTH{1'b1}};

    logic [WIDTH-1:0] nxt;
    logic             wraps;

    // next count and wrap detection for a step
    always_comb begin
        nxt   = dir_q ? count + 1'b1 : count - 1'b1;
        wraps = dir_q ? (count == ALL1) : (count == '0);
    end

    // update count; a load wins over a step at the same edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count  <= '0;
            busy   <= 1'b0;
            ripple <= 1'b0;
        end else if (ld_go) begin
            count  <= (ld_kind == pos_pkg::LD_CLEAR) ? (count & ~ld_data) : ld_data;
            busy   <= 1'b1;
            ripple <= 1'b0;
        end else begin
            if (step_q) count <= nxt;
            busy   <= step_q;
            ripple <= step_q && wraps;
        end
    end

    AST_STEP_UP: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_go && step_q && dir_q) |=> count == $past(count) + 1'b1); // R2
    AST_STEP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_go && step_q && !dir_q) |=> count == $past(count) - 1'b1); // R2
    AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_go && !step_q) |=> $stable(count) && !busy); // R5
    AST_RIPPLE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        ripple |-> busy); // R3
    AST_WRITE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_go && ld_kind == pos_pkg::LD_WRITE) |=> count == $past(ld_data)); // R6
    AST_CLEAR_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_go && ld_kind == pos_pkg::LD_CLEAR) |=> (count & $past(ld_data)) == '0); // R7
endmodule

// File: rtl/angle_pos_counter.sv
// Top of the tracking-converter position counter.
// Wires the direction stage, the load hold controller and the count core.
// It drives the data bus, which floats while outputs are disabled.
// Assumes: all inputs synchronous to clk; HOLD_CYCLES >= 1.
module angle_pos_counter #(
    parameter int WIDTH       = 12,
    parameter int HOLD_CYCLES = 25
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_i,
    input  logic             dir_i,
    input  logic             load_n_i,
    input  logic             comp_n_i,
    input  logic             oe_n_i,
    input  logic [WIDTH-1:0] data_i,
    output logic [WIDTH-1:0] data_o,
    output logic             dir_o,
    output logic             busy_o,
    output logic             ripple_o
);
    logic                step_q;
    logic                ld_go;
    pos_pkg::load_kind_e ld_kind;
    logic [WIDTH-1:0]    count;

    pos_dir_stage u_dir (
        .clk    (clk),
        .rst_n  (rst_n),
        .step_i (step_i),
        .dir_i  (dir_i),
        .step_q (step_q),
        .dir_q  (dir_o)
    );

    pos_load_hold #(.HOLD_CYCLES(HOLD_CYCLES)) u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_n_i (load_n_i),
        .oe_n_i   (oe_n_i),
        .comp_n_i (comp_n_i),
        .ld_go    (ld_go),
        .ld_kind  (ld_kind)
    );

    pos_count_core #(.WIDTH(WIDTH)) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .step_q  (step_q),
        .dir_q   (dir_o),
        .ld_go   (ld_go),
        .ld_kind (ld_kind),
        .ld_data (data_i),
        .count   (count),
        .busy    (busy_o),
        .ripple  (ripple_o)
    );

    // drive the count onto the bus only while outputs are enabled
    assign data_o = oe_n_i ? {WIDTH{1'bz}} : count;

    AST_LOAD_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        !oe_n_i |-> !ld_go); // R9
endmodule

// File: tb/sim_angle_pos_counter.sv
`timescale 1ns/1ps
module sim_angle_pos_counter;
    localparam int W    = 12;
    localparam int HOLD = 25;   // 100 ns at 250 MHz
    localparam int MOD  = 1 << W;

    logic clk = 1'b0, rst_n = 1'b0;
    logic step_i = 0, dir_i = 0, load_n_i = 1, comp_n_i = 1, oe_n_i = 0;
    logic [W-1:0] data_i = '0;
    logic [W-1:0] data_o;
    logic dir_o, busy_o, ripple_o;

    int total = 0, bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    angle_pos_counter #(.WIDTH(W), .HOLD_CYCLES(HOLD)) u0 (
        .clk(clk), .rst_n(rst_n), .step_i(step_i), .dir_i(dir_i),
        .load_n_i(load_n_i), .comp_n_i(comp_n_i), .oe_n_i(oe_n_i),
        .data_i(data_i), .data_o(data_o), .dir_o(dir_o),
        .busy_o(busy_o), .ripple_o(ripple_o)
    );

    // behavioural reference model, advanced at every rising edge
    int m_cnt = 0, m_held = 0;
    bit m_dir = 0, m_stepq = 0, m_busy = 0, m_rip = 0;
    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_held = 0; m_dir = 0; m_stepq = 0; m_busy = 0; m_rip = 0;
        end else begin
            bit active, go;
            active = !load_n_i && oe_n_i;
            go = active && (m_held == HOLD - 1);
            if (!active) m_held = 0; else if (m_held < HOLD) m_held++;
            m_busy = 0; m_rip = 0;
            if (go) begin
                m_cnt  = comp_n_i ? int'(data_i) : (m_cnt & ~int'(data_i) & (MOD - 1));
                m_busy = 1;
            end else if (m_stepq) begin
                m_busy = 1;
                if (m_dir) begin m_rip = (m_cnt == MOD - 1); m_cnt = (m_cnt + 1) % MOD; end
                else       begin m_rip = (m_cnt == 0);       m_cnt = (m_cnt + MOD - 1) % MOD; end
            end
            m_stepq = step_i;
            m_dir   = dir_i;
        end
    end

    task automatic check(string req, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // cycle-by-cycle comparison against the model, away from the edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R5 dir_o", int'(dir_o), int'(m_dir));
            check("R4 busy_o", int'(busy_o), int'(m_busy));
            check("R3 ripple_o", int'(ripple_o), int'(m_rip));
            if (!oe_n_i) check("R2 data_o", int'(data_o), m_cnt);
        end
    end

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_load(logic [W-1:0] d, logic cn, int held);
        oe_n_i = 1; data_i = d; comp_n_i = cn; load_n_i = 0;
        cyc(held);
        load_n_i = 1; comp_n_i = 1;
        cyc(1);
        oe_n_i = 0;
        cyc(1);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog: actual=expired expected=finished");
        finish_run();
    end

    initial begin
        cyc(3);
        rst_n = 1;
        #1;
        check("R1 count", int'(data_o), 0);
        check("R1 busy", int'(busy_o), 0);
        check("R1 ripple", int'(ripple_o), 0);
        check("R1 dir", int'(dir_o), 0);
        cyc(2);

        // R2: five up steps
        dir_i = 1; step_i = 1; cyc(5); step_i = 0; cyc(3);
        check("R2 up", int'(data_o), 5);

        // R3: seven down steps cross zero
        dir_i = 0; cyc(1); step_i = 1; cyc(7); step_i = 0; cyc(3);
        check("R3 down wrap", int'(data_o), MOD - 2);

        // R5: direction toggles, no steps
        for (int i = 0; i < 9; i++) begin dir_i = ~dir_i; cyc(1); end
        cyc(2);
        check("R5 toggle no move", int'(data_o), MOD - 2);

        // R6 / R7: same start, plain vs complement load
        do_load(12'h015, 1'b1, HOLD);
        check("R6 plain", int'(data_o), 12'h015);
        do_load(12'h018, 1'b1, HOLD);
        check("R6 plain2", int'(data_o), 12'h018);
        do_load(12'h015, 1'b1, HOLD);
        do_load(12'h018, 1'b0, HOLD);
        check("R7 clear mask", int'(data_o), 12'h005);

        // R8: one cycle short, then a long strobe loads once
        do_load(12'h3C3, 1'b1, HOLD - 1);
        check("R8 short strobe", int'(data_o), 12'h005);
        oe_n_i = 1; data_i = 12'h0F0; load_n_i = 0; cyc(HOLD);
        data_i = 12'h111; cyc(HOLD);
        load_n_i = 1; cyc(1); oe_n_i = 0; cyc(1);
        check("R8 long strobe once", int'(data_o), 12'h0F0);

        // R9: load ignored while outputs enabled
        data_i = 12'hABC; load_n_i = 0; cyc(HOLD + 3); load_n_i = 1; cyc(2);
        check("R9 enabled ignore", int'(data_o), 12'h0F0);

        // R10: step lands on the commit edge
        dir_i = 1; oe_n_i = 1; data_i = 12'h222; load_n_i = 0;
        cyc(HOLD - 2); step_i = 1; cyc(1); step_i = 0; cyc(1);
        load_n_i = 1; cyc(1); oe_n_i = 0; cyc(1);
        check("R10 step discarded", int'(data_o), 12'h222);

        // R3: upward wrap with ripple
        do_load(12'hFFF, 1'b1, HOLD);
        dir_i = 1; step_i = 1; cyc(1); step_i = 0; cyc(1);
        check("R3 up wrap count", int'(data_o), 0);
        check("R3 ripple pulse", int'(ripple_o), 1);
        check("R4 busy with wrap", int'(busy_o), 1);
        cyc(1);
        check("R3 ripple single", int'(ripple_o), 0);

        // R11: bus follows count as soon as outputs are enabled
        oe_n_i = 1; step_i = 1; cyc(3); step_i = 0; cyc(2);
        oe_n_i = 0; #1;
        check("R11 immediate drive", int'(data_o), 3);
        cyc(2);
        finish_run();
    end
endmodule